// File: doc/BRIEF.md
# Local ROM and Peripheral Bus Sequencer

This block runs accesses on a slow local bus that carries boot ROM, flash and simple peripheral devices. An internal host-side port hands it one request at a time: a start address, read or write, a beat count, a region code and write data. The block then steps through three phases on the bus. In the setup phase a chip select is driven and the strobe is still off. In the strobe phase an active-low read or write strobe is asserted. In the hold phase the strobe is off again and the chip select stays low. For reads, the 16-bit read data is passed back to the host.

The address path is split in two. The upper address bits go out on a wide shared address bus and stay fixed for the whole request. A separate 5-bit low address counts up on each beat of a ROM read burst. An isolate output stays high whenever a cycle is in progress, so that an external switch can separate the ROM from the fast memory lines. A direction output and an active-low enable drive an external data buffer. A ready input can stretch the strobe. When a peripheral asks for DMA and the host grants it, a DMA acknowledge takes the place of the peripheral's chip select.

Each region has its own setup, strobe and hold counts, given on a configuration input.

Top module: `lbus_ctrl`

## Requirements
- R1: Region code 0 is the boot region and drives rom_cs_n[1]. Code 1 drives rom_cs_n[0]. Codes 2 to 5 drive io_cs_n[0] to io_cs_n[3]. All selects are active low. At most one select (or dmack_n) is low at any time, and none is low while idle.
- R2: While a request runs, hi_addr equals the start address with its low 5 bits cleared. It holds that value through every beat of a burst. It is zero while idle.
- R3: low_addr takes the start address bits 4:0 at the first beat. It goes up by one, wrapping modulo 32, on each later beat of a ROM read burst. It stays steady while a strobe is asserted.
- R4: Configuration slot r sits at cfg_timing[12r+11:12r] and holds {hold, strobe, setup}, each 4 bits wide. Each beat has setup+1 cycles with the select low and both strobes high. It then has strobe+1 cycles with the strobe low, and hold+1 cycles with the select still low after the strobe is released.
- R5: A low level on iordy, seen through a two-flop synchronizer, extends the strobe. The extension applies only once the minimum strobe length has elapsed. With iordy high, the strobe length is exactly strobe+1 cycles.
- R6: isolate is high in every cycle in which a select or strobe is asserted. It is low while idle.
- R7: buf_dir is high for writes and low for reads during a cycle. buf_en_n is low only during strobe cycles. During a write strobe, io_dout carries the request's write data, and wr_n is used while rd_n stays high.
- R8: Suppose a request for an I/O region is accepted with req_dma high and dmarq high. dmack_n is then low for that cycle in place of the region's io_cs_n, and every io_cs_n stays high. If dmarq is low, the normal select is used.
- R9: A read captures io_din on the edge that releases the strobe, and rd_data holds that value. done pulses high for one cycle after each beat's hold phase, once per beat.
- R10: req_ready is high only while idle. Three kinds of request are rejected: a beat count of 0, a beat count above 32, or region code 6 or 7. A rejected request gives a one-cycle err pulse, runs no bus cycle and produces no done. A count of exactly 32 is accepted.
- R11: Only ROM-region reads burst. Writes, and any request to an I/O region, run exactly one beat whatever the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe from host, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Host grants DMA for this I/O request |
| req_region | input | 3 | Region code, selects chip select and timing slot |
| req_len | input | 6 | Beat count, 1 to 32 |
| req_addr | input | 32 | Start address |
| req_wdata | input | 16 | Write data |
| cfg_timing | input | 72 | Six 12-bit timing slots {hold, strobe, setup} |
| req_ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle pulse per completed beat |
| err | output | 1 | One-cycle pulse for a rejected request |
| rd_data | output | 16 | Captured read data |
| rom_cs_n | output | 2 | ROM chip selects, active low |
| io_cs_n | output | 4 | Peripheral chip selects, active low |
| dmack_n | output | 1 | DMA acknowledge, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| hi_addr | output | 32 | Upper address on shared lines, fixed per request |
| low_addr | output | 5 | Low address, counts through bursts |
| io_dout | output | 16 | Write data to the local data bus |
| io_din | input | 16 | Read data from the local data bus |
| iordy | input | 1 | Ready; low requests extra wait states |
| dmarq | input | 1 | Peripheral DMA request |
| isolate | output | 1 | High for the whole cycle to isolate ROM from the fast lines |
| buf_dir | output | 1 | Data buffer direction, high for write |
| buf_en_n | output | 1 | Data buffer enable, active low |

## Verification
The bench measures the setup, strobe and hold lengths beat by beat, using zero and non-zero counts. Counting a phase boundary wrongly shows up as a phase one cycle too long or too short. Burst tests start at address 30, so the low address must wrap to 0 and 1 while the upper address stays still. A counter that spills into the upper bits, or that moves hi_addr, would fail this test.

Two wait-state runs check the ready input. In the first, ready is released late, and the strobe must end exactly two cycles after the release. In the second, ready is released inside the minimum strobe, and the strobe must keep its programmed length. A missing synchronizer stage shortens the first run. A stretch applied too early lengthens the second. The remaining runs cover four cases, and a wrong result in any of them shows up as a stray chip select, a missing err, or the wrong number of done pulses:
- the reject limits at beat counts 0, 32 and 33, and at region codes 6 and 7;
- multi-beat writes, which must collapse to a single beat;
- the DMA acknowledge replacing the I/O chip select;
- the boot-region mapping of region 0.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } phase_e;

  // beat count legal range: 1 .. max_b
  function automatic logic len_in_range(input int unsigned beats, input int unsigned max_b);
    return (beats != 0) && (beats <= max_b);
  endfunction

  // region codes below n_rgn are mapped to a select
  function automatic logic rgn_valid(input int unsigned rgn, input int unsigned n_rgn);
    return rgn < n_rgn;
  endfunction

  // ROM regions occupy codes 0 .. n_rom-1
  function automatic logic rgn_is_rom(input int unsigned rgn, input int unsigned n_rom);
    return rgn < n_rom;
  endfunction

  // ROM select index driven by a ROM region code (code 0 -> highest index, boot)
  function automatic int unsigned rom_index(input int unsigned rgn, input int unsigned n_rom);
    return n_rom - 1 - rgn;
  endfunction

endpackage

// File: rtl/lbus_sync.sv
module lbus_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 32,
  parameter int TW        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_burst_ok,
  input  logic             req_rgn_ok,
  input  logic [LEN_W-1:0] req_len,
  input  logic [TW-1:0]    cfg_setup,
  input  logic [TW-1:0]    cfg_strobe,
  input  logic [TW-1:0]    cfg_hold,
  input  logic             rdy_sync,
  output phase_e           phase,
  output logic             accept,
  output logic             reject,
  output logic             strobe_end,
  output logic             beat_adv,
  output logic             done,
  output logic             err
);
  logic [TW-1:0]    cnt;
  logic [TW-1:0]    setup_q, strobe_q, hold_q;
  logic [LEN_W-1:0] beats_left;
  logic             req_ok;
  logic             last_beat;
  logic             hold_end;

  assign req_ok     = req_rgn_ok && len_in_range(int'(req_len), MAX_BEATS);
  assign accept     = (phase == ST_IDLE) && req_valid && req_ok;
  assign reject     = (phase == ST_IDLE) && req_valid && !req_ok;
  assign strobe_end = (phase == ST_STROBE) && (cnt == '0) && rdy_sync;
  assign hold_end   = (phase == ST_HOLD) && (cnt == '0);
  assign last_beat  = (beats_left == LEN_W'(1));
  assign beat_adv   = hold_end && !last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= ST_IDLE;
      cnt        <= '0;
      setup_q    <= '0;
      strobe_q   <= '0;
      hold_q     <= '0;
      beats_left <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (accept) begin
            setup_q    <= cfg_setup;
            strobe_q   <= cfg_strobe;
            hold_q     <= cfg_hold;
            cnt        <= cfg_setup;
            beats_left <= (req_burst_ok && !req_write) ? req_len : LEN_W'(1);
            phase      <= ST_SETUP;
          end else if (reject) begin
            err <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            cnt   <= strobe_q;
            phase <= ST_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (rdy_sync) begin
            cnt   <= hold_q;
            phase <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            done <= 1'b1;
            if (last_beat) begin
              phase <= ST_IDLE;
            end else begin
              beats_left <= beats_left - 1'b1;
              cnt        <= setup_q;
              phase      <= ST_SETUP;
            end
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R10: a rejected request leaves the sequencer idle
  p_reject_no_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (phase == ST_IDLE));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: strobe is never left before the minimum count has run out
  p_min_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_STROBE && cnt != '0) |=> (phase == ST_STROBE));

endmodule

// File: rtl/lbus_csdec.sv
module lbus_csdec #(
  parameter int N_ROM = 2,
  parameter int N_IO  = 4,
  parameter int RGN_W = 3
) (
  input  logic             active,
  input  logic [RGN_W-1:0] region,
  input  logic             dma_mode,
  output logic [N_ROM-1:0] rom_cs_n,
  output logic [N_IO-1:0]  io_cs_n,
  output logic             dmack_n
);
  for (genvar gr = 0; gr < N_ROM; gr++) begin : g_rom
    // ROM region code 0 maps to the top select (boot region)
    localparam int CODE = N_ROM - 1 - gr;
    assign rom_cs_n[gr] = !(active && (int'(region) == CODE));
  end

  for (genvar gi = 0; gi < N_IO; gi++) begin : g_io
    localparam int CODE = N_ROM + gi;
    assign io_cs_n[gi] = !(active && !dma_mode && (int'(region) == CODE));
  end

  assign dmack_n = !(active && dma_mode);
endmodule

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbus_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 16,
  parameter int LOW_W     = 5,
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 32,
  parameter int TW        = 4,
  parameter int N_ROM     = 2,
  parameter int N_IO      = 4,
  parameter int RGN_W     = 3,
  localparam int N_RGN    = N_ROM + N_IO,
  localparam int SLOT_W   = 3 * TW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_dma,
  input  logic [RGN_W-1:0]        req_region,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [N_RGN*SLOT_W-1:0] cfg_timing,
  output logic                    req_ready,
  output logic                    done,
  output logic                    err,
  output logic [DATA_W-1:0]       rd_data,
  output logic [N_ROM-1:0]        rom_cs_n,
  output logic [N_IO-1:0]         io_cs_n,
  output logic                    dmack_n,
  output logic                    rd_n,
  output logic                    wr_n,
  output logic [ADDR_W-1:0]       hi_addr,
  output logic [LOW_W-1:0]        low_addr,
  output logic [DATA_W-1:0]       io_dout,
  input  logic [DATA_W-1:0]       io_din,
  input  logic                    iordy,
  input  logic                    dmarq,
  output logic                    isolate,
  output logic                    buf_dir,
  output logic                    buf_en_n
);
  localparam int N_SLOT = 2 ** RGN_W;

  phase_e              phase;
  logic                accept, reject, strobe_end, beat_adv;
  logic                rdy_sync;
  logic                active, strobing, cs_any;
  logic                rgn_ok, burst_ok;
  logic [SLOT_W-1:0]   slot [N_SLOT];
  logic [SLOT_W-1:0]   slot_sel;
  logic [ADDR_W-1:0]   addr_q;
  logic [RGN_W-1:0]    region_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q, dma_q;

  // timing slots; unmapped codes read as zero
  for (genvar gs = 0; gs < N_SLOT; gs++) begin : g_slot
    if (gs < N_RGN) begin : g_map
      assign slot[gs] = cfg_timing[gs*SLOT_W +: SLOT_W];
    end else begin : g_zero
      assign slot[gs] = '0;
    end
  end

  assign slot_sel = slot[req_region];
  assign rgn_ok   = rgn_valid(int'(req_region), N_RGN);
  assign burst_ok = rgn_is_rom(int'(req_region), N_ROM);

  lbus_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (iordy),
    .q_out (rdy_sync)
  );

  lbus_seq #(.LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS), .TW(TW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_burst_ok (burst_ok),
    .req_rgn_ok   (rgn_ok),
    .req_len      (req_len),
    .cfg_setup    (slot_sel[TW-1:0]),
    .cfg_strobe   (slot_sel[2*TW-1:TW]),
    .cfg_hold     (slot_sel[3*TW-1:2*TW]),
    .rdy_sync     (rdy_sync),
    .phase        (phase),
    .accept       (accept),
    .reject       (reject),
    .strobe_end   (strobe_end),
    .beat_adv     (beat_adv),
    .done         (done),
    .err          (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      region_q <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      dma_q    <= 1'b0;
      low_addr <= '0;
      rd_data  <= '0;
    end else begin
      if (accept) begin
        addr_q   <= req_addr;
        region_q <= req_region;
        wdata_q  <= req_wdata;
        write_q  <= req_write;
        dma_q    <= req_dma && dmarq && !burst_ok;
        low_addr <= req_addr[LOW_W-1:0];
      end else if (beat_adv) begin
        low_addr <= low_addr + 1'b1;
      end
      if (strobe_end && !write_q) rd_data <= io_din;
    end
  end

  assign active    = (phase != ST_IDLE);
  assign strobing  = (phase == ST_STROBE);
  assign req_ready = (phase == ST_IDLE);

  lbus_csdec #(.N_ROM(N_ROM), .N_IO(N_IO), .RGN_W(RGN_W)) u_csdec (
    .active   (active),
    .region   (region_q),
    .dma_mode (dma_q),
    .rom_cs_n (rom_cs_n),
    .io_cs_n  (io_cs_n),
    .dmack_n  (dmack_n)
  );

  assign cs_any   = !(&rom_cs_n) || !(&io_cs_n) || !dmack_n;
  assign rd_n     = !(strobing && !write_q);
  assign wr_n     = !(strobing && write_q);
  assign hi_addr  = active ? {addr_q[ADDR_W-1:LOW_W], {LOW_W{1'b0}}} : '0;
  assign io_dout  = wdata_q;
  assign isolate  = active;
  assign buf_dir  = active && write_q;
  assign buf_en_n = !strobing;

  // R1: at most one select
  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_cs_n, ~io_cs_n, ~dmack_n}));

  // R2: upper address frozen through a request
  p_hi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (isolate && $past(isolate)) |-> $stable(hi_addr));

  // R3: low address steady under a strobe
  p_low_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(low_addr));

  // R4: select already set up when a strobe starts, still held when it ends
  p_cs_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(cs_any));
  p_cs_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> cs_any);

  // R6: isolate covers every strobe
  p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> isolate);

  // R7: buffer enable only with a strobe
  p_buf_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en_n |-> (!rd_n || !wr_n));

  // R8: DMA acknowledge replaces the peripheral select
  p_dmack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dmack_n |-> (&io_cs_n));

endmodule

// File: tb/lbus_ctrl_tb.sv
module lbus_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dma = 1'b0;
  logic [2:0]  req_region = '0;
  logic [5:0]  req_len = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [71:0] cfg = '0;
  logic        iordy = 1'b1, dmarq = 1'b0;
  logic        req_ready, done, err, dmack_n, rd_n, wr_n, isolate, buf_dir, buf_en_n;
  logic [15:0] rd_data, io_dout, io_din;
  logic [1:0]  rom_cs_n;
  logic [3:0]  io_cs_n;
  logic [31:0] hi_addr;
  logic [4:0]  low_addr;

  int checks = 0, failures = 0, cycles = 0;

  // measurement results
  int m_beats, m_setup0, m_strobe0, m_hold0, m_bad_iso, m_bad_hi, m_bad_dir, m_bad_buf;
  int m_low [32];
  int m_data [32];
  logic [1:0] m_rom_seen;
  logic [3:0] m_io_seen;
  logic m_dmack_seen, m_rd_seen, m_wr_seen, m_ready0;
  logic [15:0] m_dout;

  always #10 clk = ~clk;

  assign io_din = 16'hC300 | {11'd0, low_addr};

  lbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_dma(req_dma),
    .req_region(req_region), .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_timing(cfg), .req_ready(req_ready), .done(done), .err(err), .rd_data(rd_data),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .dmack_n(dmack_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_addr(hi_addr), .low_addr(low_addr), .io_dout(io_dout), .io_din(io_din),
    .iordy(iordy), .dmarq(dmarq), .isolate(isolate), .buf_dir(buf_dir), .buf_en_n(buf_en_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_slot(input int r, input int s, input int w, input int h);
    cfg[r*12 +: 12] = {h[3:0], w[3:0], s[3:0]};
  endtask

  // issue one request and measure each beat at the falling edges
  task automatic run_req(input int rgn, input bit wr, input bit dma, input int len,
                         input logic [31:0] addr, input logic [15:0] wd,
                         input int exp_beats, input int rel_after);
    int sc = 0, stc = 0, hc = 0;
    bit seen = 0, strobe, csany;
    logic [31:0] exp_hi;
    exp_hi = {addr[31:5], 5'd0};
    m_beats = 0; m_bad_iso = 0; m_bad_hi = 0; m_bad_dir = 0; m_bad_buf = 0;
    m_rom_seen = '0; m_io_seen = '0; m_dmack_seen = 0; m_rd_seen = 0; m_wr_seen = 0;
    m_setup0 = 0; m_strobe0 = 0; m_hold0 = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dma = dma; req_region = rgn[2:0];
    req_len = len[5:0]; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    m_ready0 = req_ready;
    for (int i = 0; i < 400; i++) begin
      if (i > 0) @(negedge clk);
      if (done) begin
        m_data[m_beats] = int'(rd_data);
        if (m_beats == 0) begin m_setup0 = sc; m_strobe0 = stc; m_hold0 = hc; end
        m_beats++;
        sc = 0; stc = 0; hc = 0; seen = 0;
      end
      if (m_beats >= exp_beats) break;
      strobe = !rd_n || !wr_n;
      csany  = (rom_cs_n != 2'b11) || (io_cs_n != 4'hF) || !dmack_n;
      if (strobe) begin
        stc++; seen = 1;
        m_low[m_beats] = int'(low_addr);
        m_dout = io_dout;
        if (buf_en_n) m_bad_buf++;
        if (rel_after > 0 && stc == rel_after) iordy = 1'b1;
      end else if (csany) begin
        if (seen) hc++; else sc++;
        if (!buf_en_n) m_bad_buf++;
      end
      if (strobe || csany) begin
        if (!isolate) m_bad_iso++;
        if (hi_addr != exp_hi) m_bad_hi++;
        if (buf_dir != wr) m_bad_dir++;
      end
      m_rom_seen |= ~rom_cs_n;
      m_io_seen  |= ~io_cs_n;
      if (!dmack_n) m_dmack_seen = 1;
      if (!rd_n) m_rd_seen = 1;
      if (!wr_n) m_wr_seen = 1;
    end
  endtask

  // after a request: no extra beat, bus back to idle
  task automatic check_idle_after(input string tag);
    int extra = 0, busy = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) extra++;
      if (isolate || rom_cs_n != 2'b11 || io_cs_n != 4'hF || !dmack_n) busy++;
    end
    chk({tag, " extra done"}, extra, 0);
    chk({tag, " bus idle"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset rom_cs_n", int'(rom_cs_n), 3);
    chk("R1 reset io_cs_n", int'(io_cs_n), 15);
    chk("R8 reset dmack_n", int'(dmack_n), 1);
    chk("R6 reset isolate", int'(isolate), 0);
    chk("R10 reset req_ready", int'(req_ready), 1);
    chk("R4 reset strobes", int'({rd_n, wr_n}), 3);
    chk("R2 reset hi_addr", int'(hi_addr), 0);
  endtask

  task automatic t_boot_read();
    set_slot(0, 2, 3, 1);
    run_req(0, 0, 0, 1, 32'h1FC0_0047, 16'h0, 1, 0);
    chk("R1 boot region drives rom_cs_n[1]", int'(m_rom_seen), 2);
    chk("R1 no io select", int'(m_io_seen), 0);
    chk("R10 ready low while busy", int'(m_ready0), 0);
    chk("R4 setup cycles", m_setup0, 3);
    chk("R4 strobe cycles", m_strobe0, 4);
    chk("R4 hold cycles", m_hold0, 2);
    chk("R9 beats", m_beats, 1);
    chk("R9 read data", m_data[0], 32'hC307);
    chk("R2 hi_addr", m_bad_hi, 0);
    chk("R6 isolate", m_bad_iso, 0);
    chk("R7 buf_dir read", m_bad_dir, 0);
    chk("R7 buf_en only in strobe", m_bad_buf, 0);
    chk("R7 rd strobe only", int'({m_rd_seen, m_wr_seen}), 2);
    check_idle_after("R9 boot read");
  endtask

  task automatic t_burst_wrap();
    set_slot(1, 1, 0, 0);
    run_req(1, 0, 0, 4, 32'h0040_123E, 16'h0, 4, 0);
    chk("R1 region 1 drives rom_cs_n[0]", int'(m_rom_seen), 1);
    chk("R9 burst beats", m_beats, 4);
    chk("R3 low beat0", m_low[0], 30);
    chk("R3 low beat1", m_low[1], 31);
    chk("R3 low beat2 wraps", m_low[2], 0);
    chk("R3 low beat3", m_low[3], 1);
    chk("R9 burst data beat2", m_data[2], 32'hC300);
    chk("R9 burst data beat3", m_data[3], 32'hC301);
    chk("R2 hi_addr frozen in burst", m_bad_hi, 0);
    check_idle_after("R11 burst");
  endtask

  task automatic t_io_write();
    set_slot(4, 0, 0, 0);
    run_req(4, 1, 0, 3, 32'h0000_0A05, 16'hBEEF, 1, 0);
    chk("R1 region 4 drives io_cs_n[2]", int'(m_io_seen), 4);
    chk("R4 zero setup", m_setup0, 1);
    chk("R4 zero strobe", m_strobe0, 1);
    chk("R4 zero hold", m_hold0, 1);
    chk("R7 wr strobe only", int'({m_rd_seen, m_wr_seen}), 1);
    chk("R7 buf_dir write", m_bad_dir, 0);
    chk("R7 write data", int'(m_dout), 32'hBEEF);
    check_idle_after("R11 write single beat");
  endtask

  task automatic t_rom_write_single();
    set_slot(0, 0, 0, 0);
    run_req(0, 1, 0, 5, 32'h1FC0_0000, 16'h1234, 1, 0);
    chk("R11 ROM write one beat", m_beats, 1);
    check_idle_after("R11 ROM write");
  endtask

  task automatic t_wait_late();
    set_slot(2, 0, 1, 0);
    iordy = 1'b0;
    repeat (3) @(negedge clk);
    run_req(2, 0, 0, 1, 32'h0000_0100, 16'h0, 1, 5);
    chk("R5 strobe extended by ready", m_strobe0, 7);
    chk("R5 setup unaffected", m_setup0, 1);
    iordy = 1'b1;
  endtask

  task automatic t_wait_early();
    set_slot(2, 0, 5, 0);
    iordy = 1'b0;
    repeat (3) @(negedge clk);
    run_req(2, 0, 0, 1, 32'h0000_0100, 16'h0, 1, 2);
    chk("R5 release within minimum", m_strobe0, 6);
    iordy = 1'b1;
  endtask

  task automatic t_dma();
    set_slot(3, 0, 1, 0);
    dmarq = 1'b1;
    run_req(3, 0, 1, 1, 32'h0000_0200, 16'h0, 1, 0);
    chk("R8 dmack asserted", int'(m_dmack_seen), 1);
    chk("R8 io selects stay high", int'(m_io_seen), 0);
    dmarq = 1'b0;
    run_req(3, 0, 1, 1, 32'h0000_0200, 16'h0, 1, 0);
    chk("R8 no dmarq uses select", int'(m_io_seen), 2);
    chk("R8 no dmack", int'(m_dmack_seen), 0);
  endtask

  task automatic t_reject(input int rgn, input int len, input string tag);
    int errs = 0, busy = 0, dn = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dma = 1'b0;
    req_region = rgn[2:0]; req_len = len[5:0]; req_addr = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    if (err) errs++;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (err) errs++;
      if (done) dn++;
      if (isolate || rom_cs_n != 2'b11 || io_cs_n != 4'hF) busy++;
    end
    chk({"R10 err pulse ", tag}, errs, 1);
    chk({"R10 no cycle ", tag}, busy, 0);
    chk({"R10 no done ", tag}, dn, 0);
  endtask

  task automatic t_max_burst();
    set_slot(0, 0, 0, 0);
    run_req(0, 0, 0, 32, 32'h1FC0_0000, 16'h0, 32, 0);
    chk("R10 32 beats accepted", m_beats, 32);
    chk("R3 last beat low", m_low[31], 31);
    check_idle_after("R10 max burst");
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot_read();
    t_burst_wrap();
    t_io_write();
    t_rom_write_single();
    t_wait_late();
    t_wait_early();
    t_dma();
    t_reject(0, 33, "len33");
    t_reject(0, 0, "len0");
    t_reject(6, 1, "region6");
    t_reject(7, 1, "region7");
    t_max_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule